// File: doc/BRIEF.md
# Dual-Mode Bidirectional Port Controller

This block drives a set of external pad cells that serve either as general-purpose I/O pins or as a multiplexed address/data bus. In I/O mode the CPU writes and reads two registers over a simple register bus. The data register holds the levels for the pins. The direction register sets each pin as an output (1) or as a tri-stated input (0). A data read merges the two sources bit by bit: a bit set as input returns the live pad level, and a bit set as output returns the register contents.

In bus mode the pins carry the address while the address-latch phase input is high. After that phase they carry write data, or they are released so that a peripheral can return read data. That data is captured on the rising edge of a decoded read strobe. A narrow sub-mode keeps the upper half of the pins as address-only and time-multiplexes the lower half. A test input forces bus mode. The direction register is held at zero whenever bus mode is active.

Top module: `dmport_ctrl`

## Requirements
- R1: After reset the data and direction registers are zero, every `pad_oe_o` bit is 0 and `bus_rdata_o` is zero.
- R2: In I/O mode `reg_wr_i` writes `reg_wdata_i` into the register chosen by `reg_sel_i` (0 = data, 1 = direction). Reading with `reg_sel_i`=1 returns the direction register.
- R3: In I/O mode `pad_oe_o` equals the direction register bit for bit, and `pad_out_o` equals the data register.
- R4: A data read (`reg_sel_i`=0) returns the data register bit for each direction bit of 1, and `pad_in_i` for each direction bit of 0.
- R5: Writing data while a bit is an input updates the data register, and that pin stays undriven.
- R6: While bus mode is active the direction register clears one clock later, and direction writes are ignored. It is still zero after I/O mode resumes.
- R7: `test_i`=1 selects bus mode even when `mode_bus_i`=0.
- R8: In full-width bus mode with `ale_i`=1, all pins are enabled and `pad_out_o` equals `bus_addr_i`.
- R9: In full-width bus mode with `ale_i`=0, the pins drive `bus_wdata_i` with all enables set when `bus_we_i`=1, and every enable is 0 when `bus_we_i`=0.
- R10: In bus mode, the clock edge at which `rd_strobe_i` is first seen high loads `pad_in_i` into `bus_rdata_o`. Holding the strobe high loads nothing more.
- R11: With `sel8_i`=1, the upper half of the pins always drives the upper half of `bus_addr_i`, and the lower half follows R8/R9 using the lower halves of the address and write data. A read captures the lower half of `pad_in_i`, and the upper half of the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bus_i | input | 1 | 1 selects address/data bus mode |
| test_i | input | 1 | Test; forces bus mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 data, 1 direction |
| reg_wdata_i | input | WIDTH | Register write data |
| reg_rdata_o | output | WIDTH | Register read data |
| bus_addr_i | input | WIDTH | Bus address |
| bus_wdata_i | input | WIDTH | Bus write data |
| bus_we_i | input | 1 | Bus write cycle |
| ale_i | input | 1 | Address phase |
| rd_strobe_i | input | 1 | Decoded read strobe |
| sel8_i | input | 1 | Narrow bus sub-mode |
| bus_rdata_o | output | WIDTH | Captured bus read data |
| pad_out_o | output | WIDTH | Pad output values |
| pad_oe_o | output | WIDTH | Pad output enables |
| pad_in_i | input | WIDTH | Pad input levels |

## Verification
The bench builds the block with its default `WIDTH` of 16, so the narrow sub-mode splits the pins into two 8-bit halves. The patterns used, 0xABCD as address and 0x9966 as read data, have distinct upper and lower bytes. A byte that comes from the wrong half, or an upper byte that is not cleared on a narrow read, changes a checked value. Mixed direction masks such as 0x00FF show whether the read merge picks its source per bit rather than for the whole word.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } dmp_reg_e;
endpackage

// File: rtl/dmp_regs.sv
module dmp_regs #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_mode,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);
  import dmp_pkg::*;

  logic             data_en;
  logic             dir_en;
  logic [WIDTH-1:0] dir_d;

  always_comb begin
    data_en = wr_en && (sel == SEL_DATA);
    dir_en  = bus_mode || (wr_en && (sel == SEL_DIR));
    dir_d   = bus_mode ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_en) data_q <= wdata;
      if (dir_en)  dir_q  <= dir_d;
    end
  end

  always_comb begin
    if (sel == SEL_DIR) rdata = dir_q;
    else                rdata = (dir_q & data_q) | (~dir_q & pad_in);
  end
endmodule

// File: rtl/dmp_pad_mux.sv
module dmp_pad_mux #(
  parameter int WIDTH = 16
) (
  input  logic             bus_mode,
  input  logic             sel8,
  input  logic             ale,
  input  logic             we,
  input  logic [WIDTH-1:0] addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] phase_val;
  logic             phase_oe;

  always_comb begin
    phase_val = ale ? addr : wdata;
    phase_oe  = ale || we;
  end

  always_comb begin
    if (!bus_mode) begin
      pad_out = data_q;
      pad_oe  = dir_q;
    end else if (sel8) begin
      pad_out = {addr[WIDTH-1:HALF], phase_val[HALF-1:0]};
      pad_oe  = {{(WIDTH-HALF){1'b1}}, {HALF{phase_oe}}};
    end else begin
      pad_out = phase_val;
      pad_oe  = {WIDTH{phase_oe}};
    end
  end
endmodule

// File: rtl/dmp_bus_seq.sv
module dmp_bus_seq #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_mode,
  input  logic             sel8,
  input  logic             rd_strobe,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] rdata_q
);
  localparam int HALF = WIDTH / 2;

  logic             rd_q;
  logic             cap_en;
  logic [WIDTH-1:0] cap_d;

  always_comb begin
    cap_en = bus_mode && rd_strobe && !rd_q;
    cap_d  = sel8 ? {{(WIDTH-HALF){1'b0}}, pad_in[HALF-1:0]} : pad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      rd_q <= rd_strobe;
      if (cap_en) rdata_q <= cap_d;
    end
  end
endmodule

// File: rtl/dmport_ctrl.sv
module dmport_ctrl #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_bus_i,
  input  logic             test_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  input  logic [WIDTH-1:0] bus_addr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  input  logic             bus_we_i,
  input  logic             ale_i,
  input  logic             rd_strobe_i,
  input  logic             sel8_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o,
  input  logic [WIDTH-1:0] pad_in_i
);
  logic             rst_meta_n;
  logic             rst_sync_n;
  logic             bus_mode;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb bus_mode = mode_bus_i || test_i;

  dmp_regs #(.WIDTH(WIDTH)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .bus_mode(bus_mode),
    .wr_en(reg_wr_i), .sel(reg_sel_i), .wdata(reg_wdata_i),
    .pad_in(pad_in_i), .rdata(reg_rdata_o),
    .data_q(data_q), .dir_q(dir_q)
  );

  dmp_pad_mux #(.WIDTH(WIDTH)) mux_i (
    .bus_mode(bus_mode), .sel8(sel8_i), .ale(ale_i), .we(bus_we_i),
    .addr(bus_addr_i), .wdata(bus_wdata_i),
    .data_q(data_q), .dir_q(dir_q),
    .pad_out(pad_out_o), .pad_oe(pad_oe_o)
  );

  dmp_bus_seq #(.WIDTH(WIDTH)) seq_i (
    .clk(clk), .rst_n(rst_sync_n), .bus_mode(bus_mode), .sel8(sel8_i),
    .rd_strobe(rd_strobe_i), .pad_in(pad_in_i), .rdata_q(bus_rdata_o)
  );
endmodule

// File: rtl/dmp_port_chk.sv
module dmp_port_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             mode_bus_i,
  input logic             test_i,
  input logic             ale_i,
  input logic             sel8_i,
  input logic             rd_strobe_i,
  input logic [WIDTH-1:0] bus_addr_i,
  input logic [WIDTH-1:0] pad_in_i,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] bus_rdata_o,
  input logic [WIDTH-1:0] dir_q
);
  localparam int HALF = WIDTH / 2;

  // R6
  dir_forced_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_bus_i || test_i) |=> (dir_q == '0));

  // R3
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_bus_i && !test_i) |-> (pad_oe_o == dir_q));

  // R8
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mode_bus_i || test_i) && ale_i && !sel8_i) |->
      ((&pad_oe_o) && (pad_out_o == bus_addr_i)));

  // R10
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mode_bus_i || test_i) && !sel8_i && $rose(rd_strobe_i)) |=>
      (bus_rdata_o == $past(pad_in_i)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !((mode_bus_i || test_i) && $rose(rd_strobe_i)) |=> $stable(bus_rdata_o));

  // R11
  upper_addr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mode_bus_i || test_i) && sel8_i) |->
      ((&pad_oe_o[WIDTH-1:HALF]) && (pad_out_o[WIDTH-1:HALF] == bus_addr_i[WIDTH-1:HALF])));
endmodule

bind dmport_ctrl dmp_port_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .mode_bus_i(mode_bus_i), .test_i(test_i),
  .ale_i(ale_i), .sel8_i(sel8_i), .rd_strobe_i(rd_strobe_i),
  .bus_addr_i(bus_addr_i), .pad_in_i(pad_in_i), .pad_out_o(pad_out_o),
  .pad_oe_o(pad_oe_o), .bus_rdata_o(bus_rdata_o), .dir_q(dir_q)
);

// File: tb/dmport_ctrl_tb_top.sv
module dmport_ctrl_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_bus_i, test_i, reg_wr_i, reg_sel_i;
  logic [W-1:0] reg_wdata_i, reg_rdata_o;
  logic [W-1:0] bus_addr_i, bus_wdata_i, bus_rdata_o;
  logic         bus_we_i, ale_i, rd_strobe_i, sel8_i;
  logic [W-1:0] pad_out_o, pad_oe_o, pad_in_i;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dmport_ctrl #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_bus_i(mode_bus_i), .test_i(test_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_we_i(bus_we_i), .ale_i(ale_i), .rd_strobe_i(rd_strobe_i), .sel8_i(sel8_i),
    .bus_rdata_o(bus_rdata_o), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .pad_in_i(pad_in_i)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [W-1:0] val);
    @(negedge clk);
    reg_sel_i = sel; reg_wdata_i = val; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [W-1:0] val);
    reg_sel_i = sel;
    #1 val = reg_rdata_o;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    pad_in_i = '0;
    reg_read(1'b0, v); check("R1 data", v, 16'h0000);
    reg_read(1'b1, v); check("R1 dir", v, 16'h0000);
    check("R1 oe", pad_oe_o, 16'h0000);
    check("R1 rdata", bus_rdata_o, 16'h0000);
  endtask

  task automatic t_port_rw();
    logic [W-1:0] v;
    reg_write(1'b1, 16'h00FF);
    reg_read(1'b1, v); check("R2 dir readback", v, 16'h00FF);
    reg_write(1'b0, 16'hA5C3);
    check("R3 oe", pad_oe_o, 16'h00FF);
    check("R3 out", pad_out_o, 16'hA5C3);
    pad_in_i = 16'h1234;
    reg_read(1'b0, v); check("R4 merged read", v, 16'h12C3);
  endtask

  task automatic t_input_write();
    logic [W-1:0] v;
    reg_write(1'b1, 16'h0000);
    reg_write(1'b0, 16'h5A5A);
    #1 check("R5 oe stays off", pad_oe_o, 16'h0000);
    reg_write(1'b1, 16'hFFFF);
    reg_read(1'b0, v); check("R5 data kept", v, 16'h5A5A);
  endtask

  task automatic t_bus16();
    logic [W-1:0] v;
    @(negedge clk);
    mode_bus_i = 1'b1; ale_i = 1'b1; bus_addr_i = 16'h8001;
    #1 check("R8 oe", pad_oe_o, 16'hFFFF);
    check("R8 addr", pad_out_o, 16'h8001);
    @(negedge clk);
    reg_read(1'b1, v); check("R6 dir cleared", v, 16'h0000);
    reg_write(1'b1, 16'hFFFF);
    reg_read(1'b1, v); check("R6 dir write ignored", v, 16'h0000);
    @(negedge clk);
    ale_i = 1'b0; bus_we_i = 1'b1; bus_wdata_i = 16'h4242;
    #1 check("R9 wdata", pad_out_o, 16'h4242);
    check("R9 oe write", pad_oe_o, 16'hFFFF);
    @(negedge clk);
    bus_we_i = 1'b0;
    #1 check("R9 released", pad_oe_o, 16'h0000);
    @(negedge clk);
    pad_in_i = 16'hBEEF; rd_strobe_i = 1'b1;
    @(negedge clk);
    check("R10 capture", bus_rdata_o, 16'hBEEF);
    pad_in_i = 16'h1111;
    @(negedge clk);
    check("R10 no recapture", bus_rdata_o, 16'hBEEF);
    rd_strobe_i = 1'b0; mode_bus_i = 1'b0;
    @(negedge clk);
    reg_read(1'b1, v); check("R6 dir zero after bus", v, 16'h0000);
    check("R6 oe after bus", pad_oe_o, 16'h0000);
  endtask

  task automatic t_test_force();
    logic [W-1:0] v;
    reg_write(1'b1, 16'h00F0);
    @(negedge clk);
    test_i = 1'b1; ale_i = 1'b1; bus_addr_i = 16'h0F0F;
    #1 check("R7 oe", pad_oe_o, 16'hFFFF);
    check("R7 addr", pad_out_o, 16'h0F0F);
    @(negedge clk);
    reg_read(1'b1, v); check("R7 dir cleared", v, 16'h0000);
    test_i = 1'b0; ale_i = 1'b0;
  endtask

  task automatic t_bus8();
    @(negedge clk);
    mode_bus_i = 1'b1; sel8_i = 1'b1; ale_i = 1'b1; bus_addr_i = 16'hABCD;
    #1 check("R11 addr phase", pad_out_o, 16'hABCD);
    check("R11 addr oe", pad_oe_o, 16'hFFFF);
    @(negedge clk);
    ale_i = 1'b0; bus_we_i = 1'b0;
    #1 check("R11 low released", pad_oe_o, 16'hFF00);
    check("R11 upper addr", pad_out_o & 16'hFF00, 16'hAB00);
    @(negedge clk);
    bus_we_i = 1'b1; bus_wdata_i = 16'h1277;
    #1 check("R11 write", pad_out_o, 16'hAB77);
    check("R11 write oe", pad_oe_o, 16'hFFFF);
    @(negedge clk);
    bus_we_i = 1'b0; pad_in_i = 16'h9966; rd_strobe_i = 1'b1;
    @(negedge clk);
    check("R11 narrow capture", bus_rdata_o, 16'h0066);
    rd_strobe_i = 1'b0; mode_bus_i = 1'b0; sel8_i = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mode_bus_i = 0; test_i = 0; reg_wr_i = 0; reg_sel_i = 0; reg_wdata_i = '0;
    bus_addr_i = '0; bus_wdata_i = '0; bus_we_i = 0; ale_i = 0;
    rd_strobe_i = 0; sel8_i = 0; pad_in_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_port_rw();
    t_input_write();
    t_bus16();
    t_test_force();
    t_bus8();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule